// File: doc/BRIEF.md
# Dual-World Random Word Buffer

This block sits after a conditioned entropy pipeline. It takes 32-bit random words from a valid/ready stream and shares them between two output FIFOs. One FIFO serves the secure world and the other serves the non-secure world. The secure FIFO has strict priority. Once it drops below half full, every accepted word goes to it until it is full again, and the non-secure FIFO gets nothing during that time. Outside a refill, words go to the non-secure FIFO while it has room and to the secure FIFO after that. The upstream stream is stalled only when neither FIFO can take a word, or while an error is pending.

Software reaches the block through a simple register port. Each access is valid for one cycle. The read data is combinational in the same cycle. A read of a FIFO window pops the head word at the next clock edge. Each world has a window, a status word and an alias of one shared control register. A bus-side secure flag marks each access, and the security bit in the control register decides whether the non-secure alias of the control register responds.

Back-pressure rules for the input stream: a word is taken on a cycle where `src_valid` and `src_ready` are both high. `src_ready` is low whenever the error flag is set, whenever `src_err` is high, or whenever both FIFOs are full. `src_ready` depends on nothing else, so the source may hold `src_valid` high for as long as it likes.

Top module: `rng_dual_buffer`

## Requirements
- R1: While the secure FIFO (8 words) holds fewer than 4 words, it is in refill mode. In refill mode every accepted word goes into the secure FIFO, and refill mode stays on until the secure FIFO holds 8 words.
- R2: No word is written into the non-secure FIFO (4 words) while refill mode is on.
- R3: Outside refill mode, an accepted word goes to the non-secure FIFO if it has room, and otherwise to the secure FIFO. When both FIFOs are full, `src_ready` is low.
- R4: The address map is: 0 secure control alias, 1 secure status, 2 secure window, 3 non-secure control alias, 4 non-secure status, 5 non-secure window. A read of a window returns the oldest word and removes it. A read of an empty window returns 0 and changes nothing.
- R5: A status word carries the fill count of its FIFO in words in bits [3:0] and the error flag in bit 31. All other bits read 0.
- R6: A high `src_err` sets a sticky error flag. The flag is cleared by writing 1 to bit 31 of either status address, and a new error in the same cycle wins over the clear. While the flag is set or `src_err` is high, `src_ready` is low.
- R7: The control register holds the security bit at bit 0 and an 8-bit source configuration field at bits [15:8]. The configuration field drives `cfg_o`. After reset the security bit is 0 and the field is 0x10. All other bits read 0.
- R8: Through the non-secure control alias, an access with `bus_secure` low reads 0 and its writes are ignored while the security bit is 1. Secure accesses through that alias always work.
- R9: Any access with `bus_secure` low to addresses 0, 1 or 2 reads 0 and has no effect: no pop, no write and no clear.
- R10: A pop and an accepted word on the same FIFO in the same cycle leave its count unchanged and keep first-in first-out order.
- R11: Reset empties both FIFOs, clears the error flag and leaves refill mode pending, so the first accepted words go to the secure FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_valid | input | 1 | Upstream word valid |
| src_data | input | 32 | Upstream random word |
| src_err | input | 1 | Upstream error indication |
| src_ready | output | 1 | Block can accept a word this cycle |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_secure | input | 1 | Access comes from the secure world |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| cfg_o | output | 8 | Source configuration field of the control register |

## Verification
The hardest case to reach is a refill that starts while the non-secure FIFO still has room. The starvation rule only matters there, and a free-running source plus random reads almost never drains both FIFOs in the order that creates it. Directed stimulus first fills both FIFOs and then empties the non-secure one. It then drains the secure FIFO to one word below half and restarts the source. During the restart it reads the non-secure status every other cycle and pops the secure window in between, so the refill and a same-cycle pop and push on the secure FIFO are checked together. Seeded random traffic then mixes error pulses, security-bit changes and accesses from both worlds against a queue model kept in the bench.

// File: rtl/rdb_pkg.sv
package rdb_pkg;
  typedef enum logic [2:0] {
    A_CTRL_S  = 3'd0,
    A_STAT_S  = 3'd1,
    A_WIN_S   = 3'd2,
    A_CTRL_NS = 3'd3,
    A_STAT_NS = 3'd4,
    A_WIN_NS  = 3'd5
  } reg_addr_e;

  localparam int SEC_BIT  = 0;
  localparam int CFG_LSB  = 8;
  localparam int CFG_W    = 8;
  localparam int ERR_BIT  = 31;
endpackage

// File: rtl/rdb_fifo.sv
module rdb_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign head    = mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != CW'(DEPTH)));

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count == '0 && !push) |=> (count == '0));

  // R10
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && count != '0) |=> (count == $past(count)));
endmodule

// File: rtl/rdb_route.sv
module rdb_route #(
  parameter int S_DEPTH  = 8,
  parameter int NS_DEPTH = 4,
  localparam int S_CW    = $clog2(S_DEPTH + 1),
  localparam int NS_CW   = $clog2(NS_DEPTH + 1),
  localparam int HALF    = S_DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_valid,
  input  logic             src_err,
  input  logic             err_q,
  input  logic [S_CW-1:0]  cnt_s,
  input  logic [NS_CW-1:0] cnt_ns,
  input  logic             pop_s_req,
  output logic             src_ready,
  output logic             push_s,
  output logic             push_ns
);
  logic fill_q, fill_now, room_s, room_ns, open, hs, pop_s_eff;
  logic [S_CW-1:0] cnt_s_next;

  assign fill_now  = fill_q || (cnt_s < S_CW'(HALF));
  assign room_s    = (cnt_s != S_CW'(S_DEPTH));
  assign room_ns   = (cnt_ns != NS_CW'(NS_DEPTH));
  assign open      = !err_q && !src_err;
  assign src_ready = open && (fill_now ? room_s : (room_ns || room_s));
  assign hs        = src_valid && src_ready;
  assign push_s    = hs && (fill_now || !room_ns);
  assign push_ns   = hs && !fill_now && room_ns;
  assign pop_s_eff = pop_s_req && (cnt_s != '0);
  assign cnt_s_next = cnt_s + S_CW'(push_s) - S_CW'(pop_s_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= 1'b0;
    else        fill_q <= fill_now && (cnt_s_next != S_CW'(S_DEPTH));
  end

  // R1
  refill_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_s < S_CW'(HALF) && src_valid && src_ready) |-> push_s);

  // R2
  ns_starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ns |-> (cnt_s >= S_CW'(HALF) && !fill_q));

  // R3
  both_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_s == S_CW'(S_DEPTH) && cnt_ns == NS_CW'(NS_DEPTH)) |-> !src_ready);

  // R3
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_s, push_ns}));

  // R6
  err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !src_ready);
endmodule

// File: rtl/rdb_regs.sv
module rdb_regs
  import rdb_pkg::*;
#(
  parameter int W        = 32,
  parameter int S_CW     = 4,
  parameter int NS_CW    = 3,
  parameter logic [CFG_W-1:0] CFG_RST = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_secure,
  input  logic [2:0]        bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [S_CW-1:0]   cnt_s,
  input  logic [NS_CW-1:0]  cnt_ns,
  input  logic [W-1:0]      head_s,
  input  logic [W-1:0]      head_ns,
  input  logic              src_err,
  output logic              pop_s,
  output logic              pop_ns,
  output logic              err_q,
  output logic [CFG_W-1:0]  cfg_o
);
  logic             sec_q;
  logic [CFG_W-1:0] cfg_q;
  logic             rd, wr, ns_ctrl_ok, ctrl_wr, clr;
  logic [W-1:0]     ctrl_word, stat_s, stat_ns;
  logic             unused_wbits;

  assign rd         = bus_valid && !bus_write;
  assign wr         = bus_valid && bus_write;
  assign ns_ctrl_ok = bus_secure || !sec_q;
  assign cfg_o      = cfg_q;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[SEC_BIT] = sec_q;
    ctrl_word[CFG_LSB +: CFG_W] = cfg_q;
    stat_s = '0;
    stat_s[S_CW-1:0] = cnt_s;
    stat_s[ERR_BIT] = err_q;
    stat_ns = '0;
    stat_ns[NS_CW-1:0] = cnt_ns;
    stat_ns[ERR_BIT] = err_q;
  end

  assign pop_s  = rd && bus_secure && (bus_addr == A_WIN_S);
  assign pop_ns = rd && (bus_addr == A_WIN_NS);

  assign ctrl_wr = wr && (((bus_addr == A_CTRL_S) && bus_secure) ||
                          ((bus_addr == A_CTRL_NS) && ns_ctrl_ok));
  assign clr = wr && bus_wdata[ERR_BIT] &&
               (((bus_addr == A_STAT_S) && bus_secure) || (bus_addr == A_STAT_NS));

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        A_CTRL_S:  if (bus_secure) bus_rdata = ctrl_word;
        A_STAT_S:  if (bus_secure) bus_rdata = stat_s;
        A_WIN_S:   if (bus_secure && cnt_s != '0) bus_rdata = head_s;
        A_CTRL_NS: if (ns_ctrl_ok) bus_rdata = ctrl_word;
        A_STAT_NS: bus_rdata = stat_ns;
        A_WIN_NS:  if (cnt_ns != '0) bus_rdata = head_ns;
        default:   bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= 1'b0;
      cfg_q <= CFG_RST;
      err_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        sec_q <= bus_wdata[SEC_BIT];
        cfg_q <= bus_wdata[CFG_LSB +: CFG_W];
      end
      if (src_err)  err_q <= 1'b1;
      else if (clr) err_q <= 1'b0;
    end
  end

  assign unused_wbits = ^{bus_wdata[W-2:CFG_LSB+CFG_W], bus_wdata[CFG_LSB-1:SEC_BIT+1]};

  // R8
  ns_alias_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !bus_secure && sec_q && bus_addr == A_CTRL_NS) |=> ($stable(sec_q) && $stable(cfg_q)));

  // R9
  sec_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_secure && bus_addr <= A_WIN_S) |-> (bus_rdata == '0 && !pop_s));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_err |=> err_q);
endmodule

// File: rtl/rng_dual_buffer.sv
module rng_dual_buffer
  import rdb_pkg::*;
#(
  parameter int W        = 32,
  parameter int S_DEPTH  = 8,
  parameter int NS_DEPTH = 4,
  parameter logic [CFG_W-1:0] CFG_RST = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_valid,
  input  logic [W-1:0]     src_data,
  input  logic             src_err,
  output logic             src_ready,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic             bus_secure,
  input  logic [2:0]       bus_addr,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  output logic [CFG_W-1:0] cfg_o
);
  localparam int S_CW  = $clog2(S_DEPTH + 1);
  localparam int NS_CW = $clog2(NS_DEPTH + 1);

  logic [S_CW-1:0]  cnt_s;
  logic [NS_CW-1:0] cnt_ns;
  logic [W-1:0]     head_s, head_ns;
  logic             push_s, push_ns, pop_s, pop_ns, err_q;

  rdb_fifo #(.W(W), .DEPTH(S_DEPTH)) u_fifo_s (
    .clk(clk), .rst_n(rst_n), .push(push_s), .wdata(src_data),
    .pop(pop_s), .head(head_s), .count(cnt_s)
  );

  rdb_fifo #(.W(W), .DEPTH(NS_DEPTH)) u_fifo_ns (
    .clk(clk), .rst_n(rst_n), .push(push_ns), .wdata(src_data),
    .pop(pop_ns), .head(head_ns), .count(cnt_ns)
  );

  rdb_route #(.S_DEPTH(S_DEPTH), .NS_DEPTH(NS_DEPTH)) u_route (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_err(src_err),
    .err_q(err_q), .cnt_s(cnt_s), .cnt_ns(cnt_ns), .pop_s_req(pop_s),
    .src_ready(src_ready), .push_s(push_s), .push_ns(push_ns)
  );

  rdb_regs #(.W(W), .S_CW(S_CW), .NS_CW(NS_CW), .CFG_RST(CFG_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_secure(bus_secure), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cnt_s(cnt_s), .cnt_ns(cnt_ns), .head_s(head_s),
    .head_ns(head_ns), .src_err(src_err), .pop_s(pop_s), .pop_ns(pop_ns),
    .err_q(err_q), .cfg_o(cfg_o)
  );
endmodule

// File: tb/sim_rng_dual_buffer.sv
module sim_rng_dual_buffer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rst_n;
  logic        src_valid, src_err, src_ready;
  logic [31:0] src_data;
  logic        bus_valid, bus_write, bus_secure;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  cfg_o;

  rng_dual_buffer u0 (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
    .src_err(src_err), .src_ready(src_ready), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_secure(bus_secure), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_o(cfg_o)
  );

  int checks = 0;
  int fails  = 0;

  logic [31:0] qs[$];
  logic [31:0] qns[$];
  bit          m_fill, m_err, m_sec;
  logic [7:0]  m_cfg;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word();
    return {16'h0, m_cfg, 7'h0, m_sec};
  endfunction

  function automatic logic [31:0] stat_word(input int n);
    return {m_err, 27'h0, 4'(n)};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [2:0] a, input bit s);
    case (a)
      3'd0: return s ? ctrl_word() : 32'h0;
      3'd1: return s ? stat_word(qs.size()) : 32'h0;
      3'd2: return (s && qs.size() > 0) ? qs[0] : 32'h0;
      3'd3: return (s || !m_sec) ? ctrl_word() : 32'h0;
      3'd4: return stat_word(qns.size());
      3'd5: return (qns.size() > 0) ? qns[0] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a, input bit s);
    if (a <= 3'd2 && !s) return "R9";
    case (a)
      3'd0: return "R7";
      3'd3: return "R8";
      3'd1, 3'd4: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic cyc(input bit v, input logic [31:0] d, input bit e, input bit bv,
                     input bit bw, input bit bs, input logic [2:0] a,
                     input logic [31:0] wd, input string tag);
    bit rdy, fill_now, ns_full;
    @(negedge clk);
    src_valid = v; src_data = d; src_err = e;
    bus_valid = bv; bus_write = bw; bus_secure = bs; bus_addr = a; bus_wdata = wd;
    #1;
    rdy = !m_err && !e && (qs.size() < 8 || qns.size() < 4);
    chk("R3/R6 ready", {31'h0, src_ready}, {31'h0, rdy});
    chk("R7 cfg", {24'h0, cfg_o}, {24'h0, m_cfg});
    if (bv && !bw) chk((tag == "") ? tag_of(a, bs) : tag, bus_rdata, exp_rd(a, bs));
    @(posedge clk);
    fill_now = m_fill || qs.size() < 4;
    ns_full  = (qns.size() == 4);
    if (bv && !bw) begin
      if (a == 3'd2 && bs && qs.size() > 0) void'(qs.pop_front());
      if (a == 3'd5 && qns.size() > 0) void'(qns.pop_front());
    end
    if (v && rdy) begin
      if (fill_now || ns_full) qs.push_back(d);
      else qns.push_back(d);
    end
    m_fill = fill_now && (qs.size() != 8);
    if (bv && bw) begin
      if ((a == 3'd0 && bs) || (a == 3'd3 && (bs || !m_sec))) begin
        m_sec = wd[0];
        m_cfg = wd[15:8];
      end
      if (wd[31] && ((a == 3'd1 && bs) || a == 3'd4)) m_err = 1'b0;
    end
    if (e) m_err = 1'b1;
  endtask

  task automatic idle_rd(input bit s, input logic [2:0] a, input string tag);
    cyc(0, 32'h0, 0, 1, 0, s, a, 32'h0, tag);
  endtask

  task automatic wr(input bit s, input logic [2:0] a, input logic [31:0] wd);
    cyc(0, 32'h0, 0, 1, 1, s, a, wd, "");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    src_valid = 0; src_data = 0; src_err = 0;
    bus_valid = 0; bus_write = 0; bus_secure = 0; bus_addr = 0; bus_wdata = 0;
    m_fill = 0; m_err = 0; m_sec = 0; m_cfg = 8'h10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    idle_rd(1, 3'd1, "R11");
    idle_rd(1, 3'd4, "R11");
    idle_rd(1, 3'd0, "R7");
    idle_rd(0, 3'd5, "R11");

    // R1/R3 fill both from empty: 8 to secure, then 4 to non-secure, then stall
    for (int i = 0; i < 14; i++) cyc(1, 32'hA000_0000 + i, 0, 0, 0, 0, 0, 0, "");
    idle_rd(1, 3'd1, "R1");
    idle_rd(0, 3'd4, "R3");
    idle_rd(0, 3'd1, "R9");
    wr(0, 3'd1, 32'h8000_0000);

    // drain non-secure, then secure to 3 words
    for (int i = 0; i < 4; i++) idle_rd(0, 3'd5, "R4");
    idle_rd(0, 3'd5, "R4");
    for (int i = 0; i < 5; i++) idle_rd(1, 3'd2, "R4");
    idle_rd(1, 3'd1, "R1");

    // refill: non-secure starved, with same-cycle pop/push on secure
    for (int i = 0; i < 10; i++) begin
      if (i % 2 == 0) cyc(1, 32'hB000_0000 + i, 0, 1, 0, 0, 3'd4, 0, "R2");
      else            cyc(1, 32'hB000_0000 + i, 0, 1, 0, 1, 3'd2, 0, "R10");
    end
    idle_rd(1, 3'd1, "R10");
    for (int i = 0; i < 4; i++) cyc(1, 32'hC000_0000 + i, 0, 1, 0, 0, 3'd4, 0, "R3");

    // R6 error handling
    cyc(1, 32'hDEAD_0001, 1, 0, 0, 0, 0, 0, "");
    idle_rd(0, 3'd4, "R6");
    cyc(1, 32'hDEAD_0002, 0, 0, 0, 0, 0, 0, "");
    wr(0, 3'd4, 32'h8000_0000);
    idle_rd(0, 3'd4, "R6");

    // R8 security bit gating
    wr(1, 3'd0, 32'h0000_3301);
    idle_rd(0, 3'd3, "R8");
    wr(0, 3'd3, 32'h0000_7700);
    idle_rd(1, 3'd3, "R8");
    wr(1, 3'd3, 32'h0000_4400);
    idle_rd(0, 3'd3, "R8");

    // seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      bit v, e, bv, bw, bs;
      logic [2:0] a;
      logic [31:0] wd;
      v  = ($urandom_range(0, 3) != 0);
      e  = ($urandom_range(0, 199) == 0);
      bv = ($urandom_range(0, 9) < 5);
      bw = ($urandom_range(0, 3) == 0);
      bs = $urandom_range(0, 1);
      a  = 3'($urandom_range(0, 6));
      wd = $urandom;
      cyc(v, $urandom, e, bv, bw, bs, a, wd, "");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule